// File: doc/BRIEF.md
# Next-Fetch Filter-Hit Route Predictor

This block sits beside a small direct-mapped filter cache in an instruction fetch path. Each fetch can be served from the filter cache or from the I-cache. For every fetch, the block decides where the following fetch goes. Each filter line has a small table entry. That entry holds a few low tag bits of the address that was fetched right after the line was last used. A register keeps the line index of the previous fetch.

When a fetch arrives, the block reads the entry at the current line index and compares it with the current address's low tag bits. If they match, the current fetch and its remembered successor probably belong to one small loop that fits in the filter cache, so the next fetch is routed to the filter cache. Otherwise the next fetch goes straight to the I-cache. In the same cycle, the entry of the previous line is trained with the current low tag bits. This training happens whichever cache serves the fetch.

A saturating counter of fetches that were routed to the I-cache is provided. A controller can use it to decide whether the filter cache is worth keeping on.

Top module: `fetch_route_predictor`

## Requirements
- R1: After reset, `routeFilter` is 0 (next fetch goes to the I-cache), `lastLine` is 0, `directCount` is 0, and every table entry is 0.
- R2: The fetch address splits into three fields, from the least significant bit up:
  - a byte offset of OFF_W bits (bits 3:0 by default);
  - a line index of IDX_W bits (bits 7:4);
  - a partial tag of PTAG_W bits (bits 11:8).
- R3: On each clock with `fetchValid` high, `lastLine` takes the line index of `fetchAddr` one cycle later.
- R4: On each clock with `fetchValid` high, the table entry addressed by the previous `lastLine` is written with the partial tag of `fetchAddr`.
- R5: On each clock with `fetchValid` high, `routeFilter` becomes 1 in the next cycle exactly when the partial tag of `fetchAddr` equals the table entry at its line index; otherwise it becomes 0. The new value applies to the next fetch.
- R6: When the entry being trained is the same entry being read for the prediction, the prediction uses the value held before the write.
- R7: Cycles with `fetchValid` low change no state: `routeFilter`, `lastLine`, `directCount` and the table all hold.
- R8: `directCount` increases by one on each clock with `fetchValid` high while `routeFilter` is 0, and it saturates at its maximum value.
- R9: Training and prediction happen on every valid fetch, whether `routeFilter` is 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetchValid | input | 1 | A fetch is issued this cycle |
| fetchAddr | input | ADDR_W | Address of the current fetch |
| routeFilter | output | 1 | 1: send the next fetch to the filter cache; 0: send it to the I-cache |
| lastLine | output | IDX_W | Debug: line index of the previous valid fetch |
| directCount | output | CNT_W | Saturating count of fetches routed to the I-cache |

## Verification
The hardest case to reach is the read/write collision: the entry being trained is the same entry being read for the prediction. This needs two back-to-back fetches that map to the same line but carry different partial tags. The stimulus first trains that line so its entry holds one tag. It then issues a fetch with a second tag to the same line, so that reading the freshly written value would predict a hit where the old value predicts a miss. Counter saturation is reached with a narrowed counter and a run of fetches that keep mispredicting.

// File: rtl/frp_pkg.sv
package frp_pkg;
  typedef struct packed {
    logic tableWr;    // train entry of previous line
    logic lineLoad;   // capture current line index
    logic routeLoad;  // capture new prediction
  } frpStrobes_t;
endpackage

// File: rtl/frp_ctrl.sv
module frp_ctrl
  import frp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetchValid,
  input  logic             routeFilter,
  output frpStrobes_t      strobes,
  output logic [CNT_W-1:0] directCount
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  logic cntInc;

  always_comb begin
    strobes.tableWr   = fetchValid;
    strobes.lineLoad  = fetchValid;
    strobes.routeLoad = fetchValid;
    cntInc            = fetchValid && !routeFilter;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      directCount <= '0;
    else if (cntInc && directCount != CntMax)
      directCount <= directCount + 1'b1;
  end

  // R8: counter steps by one on a direct-routed fetch below saturation
  p_cnt_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fetchValid && !routeFilter && directCount != CntMax)
      |=> directCount == $past(directCount) + 1'b1);

  // R8: counter never wraps
  p_cnt_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (directCount == CntMax) |=> directCount == CntMax);

  // R7: idle cycles leave the counter alone
  p_cnt_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fetchValid |=> $stable(directCount));
endmodule

// File: rtl/frp_datapath.sv
module frp_datapath
  import frp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 4,
  parameter int IDX_W  = 4,
  parameter int PTAG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  frpStrobes_t       strobes,
  output logic              routeFilter,
  output logic [IDX_W-1:0]  lastLine
);
  localparam int Lines   = 1 << IDX_W;
  localparam int TagBase = OFF_W + IDX_W;

  logic [PTAG_W-1:0] nextTag [Lines];
  logic [IDX_W-1:0]  curIdx;
  logic [PTAG_W-1:0] curTag;
  logic              predHit;

  always_comb begin
    curIdx  = fetchAddr[OFF_W +: IDX_W];
    curTag  = fetchAddr[TagBase +: PTAG_W];
    predHit = (nextTag[curIdx] == curTag);  // old contents on collision
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < Lines; i++) nextTag[i] <= '0;
    end else if (strobes.tableWr) begin
      nextTag[lastLine] <= curTag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lastLine    <= '0;
      routeFilter <= 1'b0;
    end else begin
      if (strobes.lineLoad)  lastLine    <= curIdx;
      if (strobes.routeLoad) routeFilter <= predHit;
    end
  end

  // R3: line register follows each valid fetch
  p_line_track_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.lineLoad |=> lastLine == $past(curIdx));

  // R4: trained entry holds the fetched partial tag afterwards
  p_train_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.tableWr |=> nextTag[$past(lastLine)] == $past(curTag));

  // R6: collision with differing tag predicts from old value (miss)
  p_read_old_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.routeLoad && lastLine == curIdx && nextTag[curIdx] != curTag)
      |=> !routeFilter);

  // R7: idle cycles hold route and line state
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.routeLoad |=> $stable(routeFilter) && $stable(lastLine));
endmodule

// File: rtl/fetch_route_predictor.sv
module fetch_route_predictor
  import frp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 4,
  parameter int IDX_W  = 4,
  parameter int PTAG_W = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic              routeFilter,
  output logic [IDX_W-1:0]  lastLine,
  output logic [CNT_W-1:0]  directCount
);
  frpStrobes_t strobes;

  frp_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetchValid  (fetchValid),
    .routeFilter (routeFilter),
    .strobes     (strobes),
    .directCount (directCount)
  );

  frp_datapath #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .IDX_W  (IDX_W),
    .PTAG_W (PTAG_W)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetchAddr   (fetchAddr),
    .strobes     (strobes),
    .routeFilter (routeFilter),
    .lastLine    (lastLine)
  );
endmodule

// File: tb/fetch_route_predictor_tb.sv
module fetch_route_predictor_tb;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              fetchValid = 1'b0;
  logic [ADDR_W-1:0] fetchAddr = '0;
  logic              routeFilter;
  logic [3:0]        lastLine;
  logic [CNT_W-1:0]  directCount;

  int errors = 0;
  int checks = 0;

  logic [3:0]       mTab [16];
  logic [3:0]       mPrev;
  logic             mRoute;
  logic [CNT_W-1:0] mCnt;

  always #5 clk = ~clk;

  fetch_route_predictor #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .routeFilter(routeFilter), .lastLine(lastLine), .directCount(directCount)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] mk(input logic [3:0] tg, input logic [3:0] ix);
    return {4'h0, tg, ix, 4'h3};
  endfunction

  task automatic checkAll(input string req);
    chk({req, " route"}, int'(routeFilter), int'(mRoute));
    chk({req, " line"}, int'(lastLine), int'(mPrev));
    chk({req, " count"}, int'(directCount), int'(mCnt));
  endtask

  // one valid fetch; model: read old entry, then train previous line
  task automatic fetch(input logic [3:0] tg, input logic [3:0] ix, input string req);
    @(negedge clk);
    fetchValid = 1'b1;
    fetchAddr  = mk(tg, ix);
    @(posedge clk);
    if (!mRoute && mCnt != {CNT_W{1'b1}}) mCnt = mCnt + 1'b1;
    mRoute = (mTab[ix] == tg);
    mTab[mPrev] = tg;
    mPrev = ix;
    @(negedge clk);
    fetchValid = 1'b0;
    checkAll(req);
  endtask

  task automatic testReset();
    for (int i = 0; i < 16; i++) mTab[i] = 4'h0;
    mPrev = '0; mRoute = 1'b0; mCnt = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    checkAll("R1");
    // all-zero table: tag 0 on any line predicts hit
    fetch(4'h0, 4'h9, "R1 cleared table");
  endtask

  task automatic testLoop();
    // R2 R5 R9: two-line loop; trains while routed to I-cache, then hits
    for (int k = 0; k < 4; k++) begin
      fetch(4'h1, 4'h2, "R5 loop A");
      fetch(4'h1, 4'h3, "R9 loop B");
    end
    chk("R5 loop settles to filter", int'(routeFilter), 1);
  endtask

  task automatic testDiverge();
    fetch(4'h2, 4'h2, "R5 diverge");   // entry 2 holds 1, tag 2 -> miss
    chk("R5 diverge miss", int'(routeFilter), 0);
    fetch(4'hA, 4'h5, "R4 train 2");   // entry 2 trained with A
    fetch(4'h2, 4'h2, "R4 recheck");   // entry 2 now A, tag 2 -> miss
  endtask

  task automatic testCollision();
    fetch(4'h5, 4'h7, "R6 prime");
    fetch(4'h5, 4'h7, "R6 train same"); // entry 7 = 5
    fetch(4'h7, 4'h7, "R6 collide");    // old 5 vs 7 -> miss
    chk("R6 old value used", int'(routeFilter), 0);
    fetch(4'h7, 4'h7, "R6 new value"); // entry 7 now 7 -> hit
    chk("R6 written value seen next", int'(routeFilter), 1);
  endtask

  task automatic testIdle();
    repeat (6) begin
      @(negedge clk);
      fetchAddr = mk(4'hF, 4'hE);
    end
    checkAll("R7 idle hold");
    fetch(4'h1, 4'h1, "R7 after idle");
    fetch(4'h3, 4'h7, "R7 table kept");
  endtask

  task automatic testSaturate();
    for (int k = 0; k < 24; k++)
      fetch(4'(k + 3), 4'(k % 3), "R8 saturate");
    chk("R8 at max", int'(directCount), (1 << CNT_W) - 1);
  endtask

  initial begin
    fork
      begin
        testReset();
        testLoop();
        testDiverge();
        testCollision();
        testIdle();
        testSaturate();
      end
      begin
        repeat (100000) @(posedge clk);
        chk("watchdog expired", 1, 0);
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule